// File: doc/BRIEF.md
# Gap-Timed Write Bit Decoder

This block turns a reader-to-tag downlink into a stream of decoded bits. The reader signals by briefly removing its carrier; the analog front end reports those interruptions on a gap-detect input. The information sits in the length of the carrier-on stretch between two interruptions: a short stretch means 0, a long one means 1. All lengths are counted in field-clock periods. Each period is marked by a one-cycle field-clock enable from the clock recovery logic. The system clock can run faster than that.

A frame opens with a start gap of acceptable length. After it, every carrier-on stretch that ends in a gap yields one bit. Every gap that follows a bit must itself fall inside the write-gap window. A stretch or gap of a length no window accepts flags an error and drops the frame. When the carrier stays on past the longest legal 1, the frame ends. Command parsing is left to the logic downstream, which sees a frame-start pulse, bit strobes, an end-of-frame pulse and error pulses.

Top module: `gtd_decoder`

## Requirements
- R1: After the synchronous active-high reset `rst`, all outputs are low and the block waits for a start gap. No bit, end or error pulse appears until a start gap has been accepted, including after a reset in the middle of a frame.
- R2: While waiting, a gap (gap_in = 1 on consecutive enabled samples) of 10 to 50 field clocks inclusive is accepted as a start gap. `frame_start` pulses when its end is sampled. Gaps of any other length are ignored without an error.
- R3: Inside a frame, a gap of 8 to 30 field clocks inclusive following a bit continues the frame. Any other gap length pulses `err` and returns the block to waiting.
- R4: Inside a frame, a carrier-on interval of 16 to 31 field clocks inclusive pulses `bit_vld` with `bit_val` = 0. The pulse comes on the sample that sees the following gap begin.
- R5: A carrier-on interval of 48 to 63 field clocks inclusive pulses `bit_vld` with `bit_val` = 1. `bit_val` is low whenever `bit_vld` is low.
- R6: Bits come out in the order their intervals are received, with exactly one strobe per interval.
- R7: Inside a frame, a carrier-on interval that reaches its 64th sample with no gap pulses `frame_end` on that sample and returns the block to waiting.
- R8: Inside a frame, a carrier-on interval ending in a gap with a length in neither bit window pulses `err`, emits no bit and returns the block to waiting.
- R9: Length counters saturate at their maximum (127 for the default 7-bit counter) instead of wrapping. A gap of 143 or 148 field clocks is therefore invalid, never taken as a short one.
- R10: Only cycles with `fc_en` high are sampled. Every output is a one-cycle pulse in the cycle after the sampling edge. `gap_in` changes on cycles without `fc_en` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| fc_en | input | 1 | Field-clock enable, one sample per field-clock period |
| gap_in | input | 1 | Carrier gap detect, high while the carrier is off |
| bit_vld | output | 1 | Decoded bit strobe |
| bit_val | output | 1 | Decoded bit value, qualified by bit_vld |
| frame_start | output | 1 | Start gap accepted |
| frame_end | output | 1 | Carrier held past the longest bit, frame closed |
| err | output | 1 | Gap or interval outside every window, frame dropped |

## Verification
The bench targets the edges of each window (9/10 and 50/51 for the start gap, 7/8 and 30/31 for the write gap, 15/16, 31/32, 47/48 and 63/64 for carrier intervals). A design with an off-by-one count would misclassify one side of an edge, and the error or end pulse would show up one sample early or late. Gaps of 143 and 148 field clocks catch a wrapping counter, which would accept them as 15 and 20. Garbage driven on `gap_in` between enables catches a design that samples without the enable, and a reset in mid-frame catches state left over from the old frame. Long random frames mixing valid and invalid lengths check bit order and the recovery to the waiting state after every abort.

// File: rtl/gtd_pkg.sv
`timescale 1ns/1ps
package gtd_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_DATA = 2'd1,
      ST_GAP  = 2'd2
   } gtd_state_t;

   localparam int WIN_START = 0;
   localparam int WIN_WGAP  = 1;
   localparam int WIN_ZERO  = 2;
   localparam int WIN_ONE   = 3;
   localparam int WIN_N     = 4;
endpackage

// File: rtl/gtd_window.sv
`timescale 1ns/1ps
module gtd_window #(
   parameter int W  = 7,
   parameter int LO = 1,
   parameter int HI = 2
) (
   input  logic [W-1:0] len,
   output logic         hit
);
   localparam logic [W-1:0] LO_V = W'(LO);
   localparam logic [W-1:0] HI_V = W'(HI);

   if (LO > HI) begin : g_bad_order
      $error("gtd_window: LO above HI");
   end
   if (HI >= (1 << W) - 1) begin : g_bad_range
      $error("gtd_window: HI does not fit below counter saturation");
   end

   assign hit = (len >= LO_V) && (len <= HI_V);
endmodule

// File: rtl/gtd_classify.sv
`timescale 1ns/1ps
module gtd_classify
   import gtd_pkg::*;
#(
   parameter int CNT_W  = 7,
   parameter int SG_LO  = 10,
   parameter int SG_HI  = 50,
   parameter int WG_LO  = 8,
   parameter int WG_HI  = 30,
   parameter int ZR_LO  = 16,
   parameter int ZR_HI  = 31,
   parameter int ON_LO  = 48,
   parameter int ON_HI  = 63
) (
   input  logic [CNT_W-1:0] len,
   output logic [WIN_N-1:0] hit
);
   localparam int LO_T [WIN_N] = '{SG_LO, WG_LO, ZR_LO, ON_LO};
   localparam int HI_T [WIN_N] = '{SG_HI, WG_HI, ZR_HI, ON_HI};

   if (ZR_HI >= ON_LO) begin : g_overlap
      $error("gtd_classify: zero and one windows overlap");
   end

   for (genvar i = 0; i < WIN_N; i++) begin : g_win
      gtd_window #(
         .W  (CNT_W),
         .LO (LO_T[i]),
         .HI (HI_T[i])
      ) u_win (
         .len (len),
         .hit (hit[i])
      );
   end
endmodule

// File: rtl/gtd_run_counter.sv
`timescale 1ns/1ps
module gtd_run_counter #(
   parameter int CNT_W           = 7,
   parameter bit GAP_ACTIVE_HIGH = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick,
   input  logic             gap_raw,
   output logic             run_gap,
   output logic [CNT_W-1:0] run_len,
   output logic             run_edge
);
   localparam logic [CNT_W-1:0] LEN_SAT = '1;
   localparam logic [CNT_W-1:0] LEN_ONE = CNT_W'(1);

   if (CNT_W < 2) begin : g_bad_width
      $error("gtd_run_counter: CNT_W too small");
   end

   logic gap_lvl;
   if (GAP_ACTIVE_HIGH) begin : g_pol_hi
      assign gap_lvl = gap_raw;
   end else begin : g_pol_lo
      assign gap_lvl = ~gap_raw;
   end

   assign run_edge = tick && (gap_lvl != run_gap);

   always_ff @(posedge clk) begin
      if (rst) begin
         run_gap <= 1'b0;
         run_len <= '0;
      end else if (run_edge) begin
         run_gap <= gap_lvl;
         run_len <= LEN_ONE;
      end else if (tick && (run_len != LEN_SAT)) begin
         run_len <= run_len + LEN_ONE;
      end
   end

   AST_SAT_HOLD: assert property (@(posedge clk) disable iff (rst)
      (tick && !run_edge && run_len == LEN_SAT) |=> (run_len == LEN_SAT)); // R9
   AST_RUN_RESTART: assert property (@(posedge clk) disable iff (rst)
      run_edge |=> (run_len == LEN_ONE && run_gap == $past(gap_lvl))); // R10
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
      !tick |=> ($stable(run_len) && $stable(run_gap))); // R10
endmodule

// File: rtl/gtd_fsm.sv
`timescale 1ns/1ps
module gtd_fsm
   import gtd_pkg::*;
#(
   parameter int CNT_W   = 7,
   parameter int END_LEN = 63
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick,
   input  logic             run_gap,
   input  logic             run_edge,
   input  logic [CNT_W-1:0] run_len,
   input  logic [WIN_N-1:0] win_hit,
   output logic             bit_vld,
   output logic             bit_val,
   output logic             frame_start,
   output logic             frame_end,
   output logic             err
);
   localparam logic [CNT_W-1:0] END_V = CNT_W'(END_LEN);

   gtd_state_t state_q, state_d;
   logic vld_d, val_d, fs_d, fe_d, err_d;

   always_comb begin
      state_d = state_q;
      vld_d   = 1'b0;
      val_d   = 1'b0;
      fs_d    = 1'b0;
      fe_d    = 1'b0;
      err_d   = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (run_edge && run_gap && win_hit[WIN_START]) begin
               fs_d    = 1'b1;
               state_d = ST_DATA;
            end
         end
         ST_DATA: begin
            if (run_edge) begin
               if (win_hit[WIN_ZERO]) begin
                  vld_d   = 1'b1;
                  state_d = ST_GAP;
               end else if (win_hit[WIN_ONE]) begin
                  vld_d   = 1'b1;
                  val_d   = 1'b1;
                  state_d = ST_GAP;
               end else begin
                  err_d   = 1'b1;
                  state_d = ST_IDLE;
               end
            end else if (tick && (run_len >= END_V)) begin
               fe_d    = 1'b1;
               state_d = ST_IDLE;
            end
         end
         ST_GAP: begin
            if (run_edge) begin
               if (win_hit[WIN_WGAP]) begin
                  state_d = ST_DATA;
               end else begin
                  err_d   = 1'b1;
                  state_d = ST_IDLE;
               end
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q     <= ST_IDLE;
         bit_vld     <= 1'b0;
         bit_val     <= 1'b0;
         frame_start <= 1'b0;
         frame_end   <= 1'b0;
         err         <= 1'b0;
      end else begin
         state_q     <= state_d;
         bit_vld     <= vld_d;
         bit_val     <= val_d;
         frame_start <= fs_d;
         frame_end   <= fe_d;
         err         <= err_d;
      end
   end

   AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
      frame_start |-> ($past(state_q) == ST_IDLE && state_q == ST_DATA)); // R2
   AST_BIT_FROM_DATA: assert property (@(posedge clk) disable iff (rst)
      bit_vld |-> ($past(state_q) == ST_DATA && state_q == ST_GAP)); // R4
   AST_VAL_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
      bit_val |-> bit_vld); // R5
   AST_ABORT_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
      (frame_end || err) |-> (state_q == ST_IDLE)); // R7
   AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (rst)
      $onehot0({bit_vld, frame_start, frame_end, err})); // R8
   AST_NO_TICK_NO_EVENT: assert property (@(posedge clk) disable iff (rst)
      !tick |=> !(bit_vld || frame_start || frame_end || err)); // R10
endmodule

// File: rtl/gtd_decoder.sv
`timescale 1ns/1ps
module gtd_decoder
   import gtd_pkg::*;
#(
   parameter int CNT_W           = 7,
   parameter bit GAP_ACTIVE_HIGH = 1'b1,
   parameter int SGAP_MIN        = 10,
   parameter int SGAP_MAX        = 50,
   parameter int WGAP_MIN        = 8,
   parameter int WGAP_MAX        = 30,
   parameter int ZERO_MIN        = 16,
   parameter int ZERO_MAX        = 31,
   parameter int ONE_MIN         = 48,
   parameter int ONE_MAX         = 63
) (
   input  logic clk,
   input  logic rst,
   input  logic fc_en,
   input  logic gap_in,
   output logic bit_vld,
   output logic bit_val,
   output logic frame_start,
   output logic frame_end,
   output logic err
);
   localparam int LEN_LIMIT = (1 << CNT_W) - 1;

   if (ONE_MAX >= LEN_LIMIT || SGAP_MAX >= LEN_LIMIT) begin : g_bad_limit
      $error("gtd_decoder: windows must end below counter saturation");
   end
   if (ZERO_MIN < 1 || WGAP_MIN < 1 || SGAP_MIN < 1) begin : g_bad_min
      $error("gtd_decoder: window minimum must be at least one sample");
   end

   logic             run_gap;
   logic             run_edge;
   logic [CNT_W-1:0] run_len;
   logic [WIN_N-1:0] win_hit;

   gtd_run_counter #(
      .CNT_W           (CNT_W),
      .GAP_ACTIVE_HIGH (GAP_ACTIVE_HIGH)
   ) u_cnt (
      .clk      (clk),
      .rst      (rst),
      .tick     (fc_en),
      .gap_raw  (gap_in),
      .run_gap  (run_gap),
      .run_len  (run_len),
      .run_edge (run_edge)
   );

   gtd_classify #(
      .CNT_W (CNT_W),
      .SG_LO (SGAP_MIN), .SG_HI (SGAP_MAX),
      .WG_LO (WGAP_MIN), .WG_HI (WGAP_MAX),
      .ZR_LO (ZERO_MIN), .ZR_HI (ZERO_MAX),
      .ON_LO (ONE_MIN),  .ON_HI (ONE_MAX)
   ) u_cls (
      .len (run_len),
      .hit (win_hit)
   );

   gtd_fsm #(
      .CNT_W   (CNT_W),
      .END_LEN (ONE_MAX)
   ) u_fsm (
      .clk         (clk),
      .rst         (rst),
      .tick        (fc_en),
      .run_gap     (run_gap),
      .run_edge    (run_edge),
      .run_len     (run_len),
      .win_hit     (win_hit),
      .bit_vld     (bit_vld),
      .bit_val     (bit_val),
      .frame_start (frame_start),
      .frame_end   (frame_end),
      .err         (err)
   );
endmodule

// File: tb/sim_gtd_decoder.sv
`timescale 1ns/1ps
module sim_gtd_decoder;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic fc_en = 1'b0;
   logic gap_in = 1'b0;
   logic bit_vld, bit_val, frame_start, frame_end, err;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   string ctx = "reset";

   int m_lvl = 0;
   int m_cnt = 0;
   int m_st  = 0;
   bit e_vld, e_val, e_fs, e_fe, e_err;

   always #5 clk = ~clk;

   gtd_decoder u0 (
      .clk (clk), .rst (rst), .fc_en (fc_en), .gap_in (gap_in),
      .bit_vld (bit_vld), .bit_val (bit_val), .frame_start (frame_start),
      .frame_end (frame_end), .err (err)
   );

   function automatic bit in_win(input int v, input int lo, input int hi);
      return (v >= lo) && (v <= hi);
   endfunction

   task automatic model_reset();
      m_lvl = 0; m_cnt = 0; m_st = 0;
   endtask

   // expected behaviour per sampled field clock, from the requirements
   task automatic model_step(input int lvl);
      e_vld = 0; e_val = 0; e_fs = 0; e_fe = 0; e_err = 0;
      if (lvl != m_lvl) begin
         case (m_st)
            0: if (m_lvl == 1 && in_win(m_cnt, 10, 50)) begin e_fs = 1; m_st = 1; end
            1: begin
               if (in_win(m_cnt, 16, 31)) begin e_vld = 1; m_st = 2; end
               else if (in_win(m_cnt, 48, 63)) begin e_vld = 1; e_val = 1; m_st = 2; end
               else begin e_err = 1; m_st = 0; end
            end
            default: if (in_win(m_cnt, 8, 30)) m_st = 1; else begin e_err = 1; m_st = 0; end
         endcase
         m_lvl = lvl;
         m_cnt = 1;
      end else begin
         if (m_st == 1 && m_cnt >= 63) begin e_fe = 1; m_st = 0; end
         if (m_cnt < 127) m_cnt++;
      end
   endtask

   task automatic chk(input bit got, input bit exp, input string what, input string req);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s [%s] %s got %0b expected %0b", req, ctx, what, got, exp);
      end
   endtask

   task automatic fc_tick(input int lvl);
      @(negedge clk);
      fc_en = 1'b1;
      gap_in = lvl[0];
      model_step(lvl);
      @(negedge clk);
      fc_en = 1'b0;
      gap_in = 1'($urandom);
      chk(frame_start, e_fs, "frame_start", "R2");
      chk(bit_vld, e_vld, "bit_vld", "R4");
      if (e_vld) chk(bit_val, e_val, "bit_val", "R5");
      chk(frame_end, e_fe, "frame_end", "R7");
      chk(err, e_err, "err", "R8");
      @(negedge clk);
      chk(bit_vld | bit_val | frame_start | frame_end | err, 1'b0, "pulse without fc_en", "R10");
   endtask

   task automatic run(input int lvl, input int n);
      repeat (n) fc_tick(lvl);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      fc_en = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
      model_reset();
      chk(bit_vld | bit_val | frame_start | frame_end | err, 1'b0, "outputs after reset", "R1");
   endtask

   initial begin
      void'($urandom(32'h5eed_0417));
      do_reset();

      ctx = "R1 no bits before start gap";
      run(0, 20); run(1, 60); run(0, 20); run(1, 3); run(0, 70);

      ctx = "R2 start gap edges";
      run(1, 9);  run(0, 20);
      run(1, 51); run(0, 20);
      run(1, 143); run(0, 20);           // R9 saturated start gap ignored
      run(1, 10); run(0, 70);
      run(1, 50); run(0, 70);

      ctx = "R4 R5 R6 interval edges";
      run(1, 20);
      run(0, 16); run(1, 8);
      run(0, 31); run(1, 30);
      run(0, 48); run(1, 10);
      run(0, 63); run(1, 9);
      run(0, 64); run(0, 10);            // R7 end on 64th sample

      ctx = "R8 invalid intervals";
      run(1, 12); run(0, 15); run(1, 5); run(0, 10);
      run(1, 12); run(0, 32); run(1, 5); run(0, 10);
      run(1, 12); run(0, 47); run(1, 5); run(0, 10);

      ctx = "R3 write gap edges";
      run(1, 12); run(0, 20); run(1, 7);  run(0, 20); run(1, 2); run(0, 5);
      run(1, 12); run(0, 20); run(1, 31); run(0, 20); run(1, 2); run(0, 5);

      ctx = "R9 saturated write gap";
      run(1, 12); run(0, 20); run(1, 148); run(0, 20); run(1, 2); run(0, 5);

      ctx = "R1 reset mid-frame";
      run(1, 12); run(0, 20); run(1, 10); run(0, 10);
      do_reset();
      run(0, 10); run(1, 12); run(0, 70);

      ctx = "R6 random frames";
      for (int f = 0; f < 40; f++) begin
         run(0, 1 + int'($urandom % 8));
         run(1, 5 + int'($urandom % 50));
         for (int b = 0; b < 1 + int'($urandom % 12); b++) begin
            int r;
            r = int'($urandom % 10);
            if (r < 4)      run(0, 16 + int'($urandom % 16));
            else if (r < 8) run(0, 48 + int'($urandom % 16));
            else            run(0, 1 + int'($urandom % 70));
            r = int'($urandom % 10);
            if (r < 9) run(1, 8 + int'($urandom % 23));
            else       run(1, 1 + int'($urandom % 60));
         end
         run(0, 70);
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #1900000;
      if (!done) begin
         errors++;
         $display("FAIL R1 [watchdog] run got hung expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule